// File: doc/BRIEF.md
# Chip Reset Sequencer

This block merges every reset request of the chip into a single chip-level reset. The sources are:

- a power-on pulse
- an active-low external reset pin, which goes through a glitch filter and can be turned off by a configuration enable
- a watchdog expiry
- a brown-out detect, which has its own enable
- a software reset request
- stack-full and stack-underflow events

Any active source asserts the chip reset in the same cycle, with no register in the path.

After a power-on or brown-out event the reset is held by two counters that run one after the other. First, a power-up counter advances on a slow tick from the internal oscillator. Then an oscillator start-up counter runs on the main clock. The reset is released on a main-clock edge once both counters have finished and no source is active.

Each cause is recorded in an active-low status flag that software can read and clear. A watchdog expiry while the core is asleep is not a reset: it produces a one-cycle wake pulse.

Top module: `reset_sequencer`

## Requirements
- R1: While any enabled source is active (power-on, filtered pin, watchdog while awake, enabled brown-out, software reset, stack full or stack underflow), `chip_rst` is 1 in the same cycle, without waiting for a clock edge.
- R2: The pin counts as a reset only after it has been sampled low at 4 consecutive rising clock edges. `chip_rst` rises right after the fourth such edge. A low run of 3 samples changes neither `chip_rst` nor any flag.
- R3: While `pin_en` is 0, the pin has no effect on `chip_rst` or on the flags.
- R4: After a power-on or brown-out event, `chip_rst` stays 1 until 2048 slow ticks have been sampled. It then stays 1 for 1024 further clock edges and falls at the 1024th of them.
- R5: A new brown-out or power-on event during the timing restarts both counters from zero, and the full R4 wait is measured again from that event.
- R6: While `brown_en` is 0, `brown_det` has no effect on `chip_rst` or on the flags.
- R7: When the counters have finished, `chip_rst` falls at the first rising edge at which no source is active.
- R8: `cause_n` bits are active-low, one per cause: bit 0 power-on, bit 1 pin while awake, bit 2 pin while asleep, bit 3 watchdog, bit 4 brown-out, bit 5 software, bit 6 stack full, bit 7 stack underflow. A cause drives its own bit to 0 at the next edge and touches no other bit.
- R9: A cycle with `flag_wr`=1 sets each bit whose `flag_wdata` bit is 1 back to 1. Bits written with 0 keep their value. A cause active in the same cycle wins over the write.
- R10: A power-on initialises `cause_n` to 8'hFE.
- R11: A watchdog expiry while `sleep_i`=1 does not assert `chip_rst` and does not change any flag. `wake_o` is 1 for the cycle after each edge at which that expiry was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| por_in | input | 1 | Power-on pulse, active high, also the block's own synchronous reset |
| pin_rst_n | input | 1 | External reset pin, active low |
| pin_en | input | 1 | Configuration enable for the pin |
| sleep_i | input | 1 | Core is in sleep |
| wdog_exp | input | 1 | Watchdog expiry |
| brown_det | input | 1 | Digital brown-out detect |
| brown_en | input | 1 | Brown-out source enable |
| sw_rst | input | 1 | Software reset request |
| stk_full | input | 1 | Stack full event |
| stk_under | input | 1 | Stack underflow event |
| slow_tick | input | 1 | One-cycle tick from the internal slow oscillator |
| flag_wr | input | 1 | Software write strobe for the cause flags |
| flag_wdata | input | 8 | Write-one-to-clear mask for the flags |
| chip_rst | output | 1 | Chip-level reset, active high |
| wake_o | output | 1 | Wake pulse for a watchdog expiry during sleep |
| cause_n | output | 8 | Active-low cause flags |

## Verification
Some rules are checked by assertions on every cycle:

- A filtered pin reset is only ever reported after a low sample.
- The timer restarts from zero on each power-on or brown-out event, enters start-up counting only on the last power-up tick, and stays finished once it has finished.
- Every flag change is traced to its own cause, to a software write or to power-on.
- A watchdog expiry during sleep always produces the wake pulse.

Other rules can only be shown by the bench's scenarios:

- the exact release edge after 2048 ticks and 1024 clocks;
- the restart of the full wait by a brown-out in the middle of the timing;
- the three-sample pin pulse that is rejected;
- the disabled pin and brown-out sources;
- the precedence of a cause over a software write in the same cycle.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_PWRT = 2'd0,
    SEQ_OST  = 2'd1,
    SEQ_DONE = 2'd2
  } seq_state_e;

  localparam int CAUSES     = 8;
  localparam int C_POWER    = 0;
  localparam int C_PIN_RUN  = 1;
  localparam int C_PIN_SLP  = 2;
  localparam int C_WDOG     = 3;
  localparam int C_BROWN    = 4;
  localparam int C_SWRST    = 5;
  localparam int C_STKFULL  = 6;
  localparam int C_STKUNDER = 7;
endpackage

// File: rtl/rst_pin_filter.sv
module rst_pin_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  input  logic enable,
  output logic valid_o
);
  localparam int CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] FULL = CW'(FILT_LEN);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (!enable || pin_n) begin
      cnt_q <= '0;
    end else if (cnt_q != FULL) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign valid_o = enable && (cnt_q == FULL);

  // R2
  pin_low_seen_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $past(!pin_n));

  // R3
  pin_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |-> !valid_o);
endmodule

// File: rtl/rst_seq_timer.sv
module rst_seq_timer
  import rst_seq_pkg::*;
#(
  parameter int PWRT_BITS = 11,
  parameter int OST_BITS  = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic tick,
  output logic done_o
);
  localparam int CW = (PWRT_BITS > OST_BITS) ? PWRT_BITS : OST_BITS;
  localparam logic [CW-1:0] PWRT_LAST = CW'((64'd1 << PWRT_BITS) - 64'd1);
  localparam logic [CW-1:0] OST_LAST  = CW'((64'd1 << OST_BITS) - 64'd1);

  seq_state_e    st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      st_q  <= SEQ_PWRT;
      cnt_q <= '0;
    end else begin
      case (st_q)
        SEQ_PWRT: begin
          if (tick) begin
            if (cnt_q == PWRT_LAST) begin
              st_q  <= SEQ_OST;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        SEQ_OST: begin
          if (cnt_q == OST_LAST) begin
            st_q  <= SEQ_DONE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: cnt_q <= '0;
      endcase
    end
  end

  assign done_o = (st_q == SEQ_DONE);

  // R5
  restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> (st_q == SEQ_PWRT) && (cnt_q == '0));

  // R4
  pwrt_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == SEQ_OST) && ($past(st_q) == SEQ_PWRT) |-> $past(tick && (cnt_q == PWRT_LAST)));

  // R4
  pwrt_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == SEQ_PWRT) && !tick && !restart |=> $stable(cnt_q));

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    done_o && !restart |=> done_o);
endmodule

// File: rtl/rst_cause_flags.sv
module rst_cause_flags #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         por,
  input  logic [N-1:0] evt,
  input  logic         wr_en,
  input  logic [N-1:0] wr_data,
  output logic [N-1:0] flags_n
);
  localparam logic [N-1:0] INIT_V = ~(N'(1));

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (por) begin
        flags_n[i] <= INIT_V[i];
      end else if (evt[i]) begin
        flags_n[i] <= 1'b0;
      end else if (wr_en && wr_data[i]) begin
        flags_n[i] <= 1'b1;
      end
    end

    // R8
    flag_fall_chk: assert property (@(posedge clk) disable iff (por)
      $fell(flags_n[i]) |-> $past(evt[i] || por));

    // R9
    flag_rise_chk: assert property (@(posedge clk) disable iff (por)
      $rose(flags_n[i]) |-> $past((wr_en && wr_data[i] && !evt[i]) || por));
  end

  // R10
  flag_init_chk: assert property (@(posedge clk)
    $past(por) |-> (flags_n == INIT_V));
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
  import rst_seq_pkg::*;
#(
  parameter int FILT_LEN  = 4,
  parameter int PWRT_BITS = 11,
  parameter int OST_BITS  = 10
) (
  input  logic              clk,
  input  logic              por_in,
  input  logic              pin_rst_n,
  input  logic              pin_en,
  input  logic              sleep_i,
  input  logic              wdog_exp,
  input  logic              brown_det,
  input  logic              brown_en,
  input  logic              sw_rst,
  input  logic              stk_full,
  input  logic              stk_under,
  input  logic              slow_tick,
  input  logic              flag_wr,
  input  logic [CAUSES-1:0] flag_wdata,
  output logic              chip_rst,
  output logic              wake_o,
  output logic [CAUSES-1:0] cause_n
);
  logic              pin_ok;
  logic              brown_act;
  logic              tim_done;
  logic              hold_q;
  logic              wake_q;
  logic              cause_any;
  logic [CAUSES-1:0] evt;

  rst_pin_filter #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk     (clk),
    .rst     (por_in),
    .pin_n   (pin_rst_n),
    .enable  (pin_en),
    .valid_o (pin_ok)
  );

  assign brown_act = brown_en && brown_det;

  always_comb begin
    evt             = '0;
    evt[C_POWER]    = por_in;
    evt[C_PIN_RUN]  = pin_ok && !sleep_i;
    evt[C_PIN_SLP]  = pin_ok && sleep_i;
    evt[C_WDOG]     = wdog_exp && !sleep_i;
    evt[C_BROWN]    = brown_act;
    evt[C_SWRST]    = sw_rst;
    evt[C_STKFULL]  = stk_full;
    evt[C_STKUNDER] = stk_under;
  end

  assign cause_any = |evt;

  rst_seq_timer #(.PWRT_BITS(PWRT_BITS), .OST_BITS(OST_BITS)) u_timer (
    .clk     (clk),
    .rst     (por_in),
    .restart (brown_act),
    .tick    (slow_tick),
    .done_o  (tim_done)
  );

  rst_cause_flags #(.N(CAUSES)) u_flags (
    .clk     (clk),
    .por     (por_in),
    .evt     (evt),
    .wr_en   (flag_wr),
    .wr_data (flag_wdata),
    .flags_n (cause_n)
  );

  always_ff @(posedge clk) begin
    if (por_in) begin
      hold_q <= 1'b1;
      wake_q <= 1'b0;
    end else begin
      hold_q <= cause_any;
      wake_q <= wdog_exp && sleep_i;
    end
  end

  assign chip_rst = cause_any || hold_q || !tim_done;
  assign wake_o   = wake_q;

  // R7
  release_when_done_chk: assert property (@(posedge clk) disable iff (por_in)
    !chip_rst |-> tim_done);

  // R11
  sleep_wake_chk: assert property (@(posedge clk) disable iff (por_in)
    wdog_exp && sleep_i |=> wake_o);

  // R1
  pin_asserts_chk: assert property (@(posedge clk) disable iff (por_in)
    pin_ok |-> chip_rst);
endmodule

// File: tb/reset_sequencer_tb.sv
module reset_sequencer_tb;
  logic       clk = 1'b0;
  logic       por_in = 1'b1;
  logic       pin_rst_n = 1'b1;
  logic       pin_en = 1'b1;
  logic       sleep_i = 1'b0;
  logic       wdog_exp = 1'b0;
  logic       brown_det = 1'b0;
  logic       brown_en = 1'b1;
  logic       sw_rst = 1'b0;
  logic       stk_full = 1'b0;
  logic       stk_under = 1'b0;
  logic       slow_tick = 1'b0;
  logic       flag_wr = 1'b0;
  logic [7:0] flag_wdata = 8'h00;
  logic       chip_rst;
  logic       wake_o;
  logic [7:0] cause_n;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  reset_sequencer u_dut (
    .clk(clk), .por_in(por_in), .pin_rst_n(pin_rst_n), .pin_en(pin_en),
    .sleep_i(sleep_i), .wdog_exp(wdog_exp), .brown_det(brown_det),
    .brown_en(brown_en), .sw_rst(sw_rst), .stk_full(stk_full),
    .stk_under(stk_under), .slow_tick(slow_tick), .flag_wr(flag_wr),
    .flag_wdata(flag_wdata), .chip_rst(chip_rst), .wake_o(wake_o),
    .cause_n(cause_n)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] next_flags(logic [7:0] f, logic [7:0] ev,
                                            logic wr, logic [7:0] wd);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      if (ev[i]) r[i] = 1'b0;
      else if (wr && wd[i]) r[i] = 1'b1;
      else r[i] = f[i];
    end
    return r;
  endfunction

  // Measures the R4 hold window, starting at the edge that sampled the event
  task automatic run_seq(string tag);
    int seen = 0;
    int ph = 0;
    int bad = 0;
    while (seen < 2048) begin
      @(negedge clk);
      if (!chip_rst) bad++;
      slow_tick = (ph % 4 == 3);
      ph++;
      @(posedge clk);
      if (slow_tick) seen++;
    end
    @(negedge clk);
    slow_tick = 1'b0;
    if (!chip_rst) bad++;
    for (int i = 1; i <= 1024; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (i < 1024 && !chip_rst) bad++;
      if (i == 1024) chk({tag, " released at 1024th clock"}, chip_rst, 0);
    end
    chk({tag, " held through timing"}, bad, 0);
  endtask

  task automatic write_flags(logic [7:0] d);
    @(negedge clk);
    flag_wr = 1'b1;
    flag_wdata = d;
    @(negedge clk);
    flag_wr = 1'b0;
    flag_wdata = 8'h00;
  endtask

  task automatic pin_low(int n, logic en, logic slp, string tag, logic exp_rst);
    @(negedge clk);
    pin_en = en;
    sleep_i = slp;
    pin_rst_n = 1'b0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (i < 4 || !en) chk({tag, " no reset before 4 samples"}, chip_rst, 0);
      else if (i == 4) chk({tag, " reset after 4th sample"}, chip_rst, exp_rst);
    end
    pin_rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({tag, " released"}, chip_rst, 0);
    pin_en = 1'b1;
    sleep_i = 1'b0;
  endtask

  initial begin : main
    logic [7:0] mflags;
    logic       mhold;
    logic       mwake;
    logic       cnow;
    void'($urandom(32'd1234));

    // R10: power-on state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 flags after power-on", cause_n, 8'hFE);
    chk("R1 reset during power-on", chip_rst, 1);
    por_in = 1'b0;
    run_seq("R4 power-on");
    chk("R10 flags after release", cause_n, 8'hFE);

    // R9: write-one sets, write-zero keeps
    write_flags(8'h00);
    chk("R9 zero write keeps", cause_n, 8'hFE);
    write_flags(8'hFF);
    chk("R9 one write sets", cause_n, 8'hFF);

    // R2: a three-sample pulse is rejected
    pin_low(3, 1'b1, 1'b0, "R2 short", 1'b0);
    chk("R2 short pulse flags", cause_n, 8'hFF);
    // R2/R8: a four-sample pulse while awake
    pin_low(5, 1'b1, 1'b0, "R2 long", 1'b1);
    chk("R8 pin run flag", cause_n, 8'hFD);
    write_flags(8'hFF);
    // R8: pin while asleep
    pin_low(4, 1'b1, 1'b1, "R8 sleep pin", 1'b1);
    chk("R8 pin sleep flag", cause_n, 8'hFB);
    write_flags(8'hFF);
    // R3: disabled pin
    pin_low(6, 1'b0, 1'b0, "R3 disabled pin", 1'b0);
    chk("R3 flags untouched", cause_n, 8'hFF);

    // R6: brown-out ignored when disabled
    @(negedge clk);
    brown_en = 1'b0;
    brown_det = 1'b1;
    #1 chk("R6 no reset from disabled brown-out", chip_rst, 0);
    @(negedge clk);
    brown_det = 1'b0;
    brown_en = 1'b1;
    chk("R6 no reset after disabled brown-out", chip_rst, 0);
    chk("R6 flags untouched", cause_n, 8'hFF);

    // R11: watchdog during sleep only wakes
    @(negedge clk);
    sleep_i = 1'b1;
    wdog_exp = 1'b1;
    #1 chk("R11 no reset in sleep", chip_rst, 0);
    @(negedge clk);
    wdog_exp = 1'b0;
    sleep_i = 1'b0;
    chk("R11 wake pulse", wake_o, 1);
    chk("R11 no flag", cause_n, 8'hFF);
    @(negedge clk);
    chk("R11 wake one cycle", wake_o, 0);

    // R9: a cause wins over a write in the same cycle
    @(negedge clk);
    sw_rst = 1'b1;
    flag_wr = 1'b1;
    flag_wdata = 8'hFF;
    @(negedge clk);
    sw_rst = 1'b0;
    flag_wr = 1'b0;
    flag_wdata = 8'h00;
    chk("R9 cause beats write", cause_n, 8'hDF);
    @(negedge clk);
    chk("R7 release after software reset", chip_rst, 0);
    write_flags(8'hFF);

    // R5: brown-out during power-up timing restarts
    @(negedge clk);
    por_in = 1'b1;
    @(negedge clk);
    por_in = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      slow_tick = (i % 4 == 3);
      @(negedge clk);
    end
    slow_tick = 1'b0;
    chk("R5 still held mid-timing", chip_rst, 1);
    brown_det = 1'b1;
    @(posedge clk);
    @(negedge clk);
    brown_det = 1'b0;
    run_seq("R5 restarted");
    chk("R8 brown flag", cause_n, 8'hEE);
    write_flags(8'hFF);

    // R1/R7/R8/R9/R11: random mix of sources and writes
    mflags = cause_n;
    mhold = 1'b0;
    mwake = 1'b0;
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] ev;
      @(negedge clk);
      chk("R8 flags random", cause_n, mflags);
      chk("R11 wake random", wake_o, mwake);
      sleep_i   = ($urandom % 4) == 0;
      wdog_exp  = ($urandom % 8) == 0;
      sw_rst    = ($urandom % 10) == 0;
      stk_full  = ($urandom % 12) == 0;
      stk_under = ($urandom % 12) == 0;
      flag_wr   = ($urandom % 4) == 0;
      flag_wdata = 8'($urandom);
      #1;
      cnow = (wdog_exp && !sleep_i) || sw_rst || stk_full || stk_under;
      chk("R1 R7 chip reset random", chip_rst, cnow || mhold);
      ev = 8'h00;
      ev[3] = wdog_exp && !sleep_i;
      ev[5] = sw_rst;
      ev[6] = stk_full;
      ev[7] = stk_under;
      @(posedge clk);
      mflags = next_flags(mflags, ev, flag_wr, flag_wdata);
      mhold = cnow;
      mwake = wdog_exp && sleep_i;
    end
    @(negedge clk);
    sleep_i = 1'b0; wdog_exp = 1'b0; sw_rst = 1'b0;
    stk_full = 1'b0; stk_under = 1'b0; flag_wr = 1'b0;
    chk("R8 flags final", cause_n, mflags);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule